// File: doc/BRIEF.md
# Token Ring Node Interface

This block is one station on a unidirectional ring. Every ring cycle, one word moves one hop. A single token word travels around the ring. A station may put its own words onto the ring only while it holds that token. The node sits between an upstream ring link and a downstream ring link. It serves a local initiator, which posts transfer requests, and an attached target, which owns a contiguous address window.

Arriving words are handled in three ways:
- A data word whose address falls inside the target window is taken off the ring and handed to the target.
- Any other data word is passed downstream one cycle later, unchanged.
- The token is either passed on, when the node has no work, or kept, when a posted transfer is still open.

While the node keeps the token it emits one word per free slot, up to a parameterised holding limit. It then releases the token. A transfer longer than the limit resumes at a later token visit, starting at the next address. One node, chosen by parameter, holds the token out of reset so that the ring starts with exactly one token.

Top module: `tr_node`

## Requirements
- R1: Out of reset the ring output carries no word, the target strobe is low and the request ready is high. A node built with `INJECT_TOKEN=1` instead presents a token word (valid and token flag high) on its ring output.
- R2: A token that arrives while no transfer is open is presented on the ring output in the next cycle with valid and token flag high.
- R3: A token that arrives while a transfer is open is kept. In the next cycle the first word of the transfer appears on the ring output at the request address. Further words follow in later free slots at consecutive addresses, with the token flag low and the direction flag equal to the request's direction.
- R4: During one token visit the node emits at most `MAX_HOLD` words. In the first free slot after the last of them, it emits the token.
- R5: When the final word of a transfer appears on the ring output, `req_done_o` pulses high in that same cycle. The token follows in the next free slot.
- R6: Words left over after a token visit are sent at the next token visit, continuing from the address after the last word sent.
- R7: An arriving data word with an address in [`BASE`, `LIMIT`] (both ends inclusive) is delivered on the target port in the next cycle. It is not placed back on the ring.
- R8: An arriving data word outside [`BASE`, `LIMIT`] appears on the ring output one cycle later, with the same address, data and direction.
- R9: While the node holds the token, an arriving word that must be forwarded takes the slot. The node's own word waits one cycle, and the word count and address sequence do not change.
- R10: A request with length 0 pulses `req_done_o` in the next cycle and sends nothing. A token arriving afterwards is forwarded.
- R11: Write words (direction 1) carry `snd_data_i` and pulse `snd_pop_o` in the cycle the word is emitted. Read words (direction 0) carry zero data and do not pulse `snd_pop_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Ring clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rin_vld_i | input | 1 | Upstream word present |
| rin_tok_i | input | 1 | Upstream word is the token |
| rin_wr_i | input | 1 | Upstream word direction (1 = write) |
| rin_addr_i | input | ADDR_W | Upstream word address |
| rin_data_i | input | DATA_W | Upstream word data |
| rout_vld_o | output | 1 | Downstream word present |
| rout_tok_o | output | 1 | Downstream word is the token |
| rout_wr_o | output | 1 | Downstream word direction |
| rout_addr_o | output | ADDR_W | Downstream word address |
| rout_data_o | output | DATA_W | Downstream word data |
| req_vld_i | input | 1 | Local request strobe |
| req_rdy_o | output | 1 | Node can take a request |
| req_addr_i | input | ADDR_W | Start address of the request |
| req_len_i | input | CNT_W | Number of words |
| req_wr_i | input | 1 | Direction of the request (1 = write) |
| req_done_o | output | 1 | Pulse when the request is finished |
| snd_data_i | input | DATA_W | Next write data word |
| snd_pop_o | output | 1 | Write data word consumed |
| slv_vld_o | output | 1 | Word delivered to the target |
| slv_wr_o | output | 1 | Direction of delivered word |
| slv_addr_o | output | ADDR_W | Address of delivered word |
| slv_data_o | output | DATA_W | Data of delivered word |

## Verification
The bench uses a holding limit of 3 and a five-word write, so a transfer must span two token visits. A node that ignored the limit would send all five words at once. A node that did not advance the address would repeat 0x0300 at the second visit.

Addresses exactly at, and one beyond, each end of the target window are sent through the node. An off-by-one comparison would either swallow a foreign word or leak a local one.

A foreign word injected during a burst checks that the node yields the slot. A design that overwrote it would lose that word; one that counted the stalled slot would send one word too few.

Two further cases are covered:
- A zero-length request must complete without leaving the node stuck holding the token.
- A read transfer must not consume write data.

// File: rtl/tr_node_pkg.sv
package tr_node_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } hold_st_e;
endpackage

// File: rtl/tr_addr_match.sv
module tr_addr_match #(
  parameter int unsigned      ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE  = '0,
  parameter logic [ADDR_W-1:0] LIMIT = '1
) (
  input  logic              vld_i,
  input  logic              tok_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  logic ge_base, le_limit;

  assign ge_base  = (addr_i >= BASE);
  assign le_limit = (addr_i <= LIMIT);
  assign hit_o    = vld_i && !tok_i && ge_base && le_limit;
endmodule

// File: rtl/tr_tx_ctrl.sv
module tr_tx_ctrl
  import tr_node_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned MAX_HOLD = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tok_in_i,
  input  logic              slot_free_i,
  input  logic              req_vld_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [CNT_W-1:0]  req_len_i,
  input  logic              req_wr_i,
  output logic              req_rdy_o,
  output logic              req_done_o,
  output logic              emit_data_o,
  output logic              emit_tok_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              cur_wr_o,
  output logic              holding_o,
  output logic              job_o,
  output logic              snd_pop_o
);
  localparam int unsigned HC_W = $clog2(MAX_HOLD + 1);
  localparam logic [HC_W-1:0] HOLD_LIM = HC_W'(MAX_HOLD);

  hold_st_e          st_q, st_n;
  logic [CNT_W-1:0]  rem_q;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [HC_W-1:0]   hcnt_q;
  logic              done_q;
  logic              job, limit_hit, accept;

  assign job       = (rem_q != '0);
  assign limit_hit = (hcnt_q == HOLD_LIM);
  assign req_rdy_o = !job && (st_q == ST_IDLE);
  assign accept    = req_vld_i && req_rdy_o;

  always_comb begin
    st_n        = st_q;
    emit_data_o = 1'b0;
    emit_tok_o  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (tok_in_i) begin
          if (job) begin
            emit_data_o = 1'b1;
            st_n        = ST_HOLD;
          end else begin
            emit_tok_o = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (!job || limit_hit) begin
          if (slot_free_i) begin
            emit_tok_o = 1'b1;
            st_n       = ST_IDLE;
          end
        end else if (slot_free_i) begin
          emit_data_o = 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      rem_q  <= '0;
      addr_q <= '0;
      wr_q   <= 1'b0;
      hcnt_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      done_q <= (accept && (req_len_i == '0)) ||
                (emit_data_o && (rem_q == CNT_W'(1)));
      if (accept) begin
        rem_q  <= req_len_i;
        addr_q <= req_addr_i;
        wr_q   <= req_wr_i;
      end else if (emit_data_o) begin
        rem_q  <= rem_q - CNT_W'(1);
        addr_q <= addr_q + ADDR_W'(1);
      end
      if (emit_tok_o)       hcnt_q <= '0;
      else if (emit_data_o) hcnt_q <= hcnt_q + HC_W'(1);
    end
  end

  assign req_done_o = done_q;
  assign cur_addr_o = addr_q;
  assign cur_wr_o   = wr_q;
  assign holding_o  = (st_q == ST_HOLD);
  assign job_o      = job;
  assign snd_pop_o  = emit_data_o && wr_q;

  // R4: word count within one visit never exceeds the limit
  a_r4_hold_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hcnt_q <= HOLD_LIM);

  // R9: a single token means none can arrive while one is held
  a_r9_no_second_token: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HOLD) |-> !tok_in_i);

  // R6: remaining count falls by exactly one per emitted word
  a_r6_rem_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emit_data_o && !accept) |=> (rem_q == $past(rem_q) - CNT_W'(1)));
endmodule

// File: rtl/tr_out_stage.sv
module tr_out_stage #(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned DATA_W       = 32,
  parameter bit          INJECT_TOKEN = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              emit_data_i,
  input  logic              emit_tok_i,
  input  logic [ADDR_W-1:0] cur_addr_i,
  input  logic              cur_wr_i,
  input  logic [DATA_W-1:0] snd_data_i,
  input  logic              rin_vld_i,
  input  logic              rin_tok_i,
  input  logic              rin_wr_i,
  input  logic [ADDR_W-1:0] rin_addr_i,
  input  logic [DATA_W-1:0] rin_data_i,
  input  logic              rin_hit_i,
  output logic              rout_vld_o,
  output logic              rout_tok_o,
  output logic              rout_wr_o,
  output logic [ADDR_W-1:0] rout_addr_o,
  output logic [DATA_W-1:0] rout_data_o,
  output logic              slv_vld_o,
  output logic              slv_wr_o,
  output logic [ADDR_W-1:0] slv_addr_o,
  output logic [DATA_W-1:0] slv_data_o
);
  logic fwd;

  assign fwd = rin_vld_i && !rin_tok_i && !rin_hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rout_vld_o  <= INJECT_TOKEN;
      rout_tok_o  <= INJECT_TOKEN;
      rout_wr_o   <= 1'b0;
      rout_addr_o <= '0;
      rout_data_o <= '0;
    end else if (emit_data_i) begin
      rout_vld_o  <= 1'b1;
      rout_tok_o  <= 1'b0;
      rout_wr_o   <= cur_wr_i;
      rout_addr_o <= cur_addr_i;
      rout_data_o <= cur_wr_i ? snd_data_i : '0;
    end else if (emit_tok_i) begin
      rout_vld_o  <= 1'b1;
      rout_tok_o  <= 1'b1;
      rout_wr_o   <= 1'b0;
      rout_addr_o <= '0;
      rout_data_o <= '0;
    end else if (fwd) begin
      rout_vld_o  <= 1'b1;
      rout_tok_o  <= 1'b0;
      rout_wr_o   <= rin_wr_i;
      rout_addr_o <= rin_addr_i;
      rout_data_o <= rin_data_i;
    end else begin
      rout_vld_o  <= 1'b0;
      rout_tok_o  <= 1'b0;
      rout_wr_o   <= 1'b0;
      rout_addr_o <= '0;
      rout_data_o <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slv_vld_o  <= 1'b0;
      slv_wr_o   <= 1'b0;
      slv_addr_o <= '0;
      slv_data_o <= '0;
    end else begin
      slv_vld_o <= rin_hit_i;
      if (rin_hit_i) begin
        slv_wr_o   <= rin_wr_i;
        slv_addr_o <= rin_addr_i;
        slv_data_o <= rin_data_i;
      end
    end
  end

  // R9: own word, token and forwarded word never compete for one slot
  a_r9_one_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({emit_data_i, emit_tok_i, fwd}));
endmodule

// File: rtl/tr_node.sv
module tr_node #(
  parameter int unsigned       ADDR_W       = 16,
  parameter int unsigned       DATA_W       = 32,
  parameter int unsigned       CNT_W        = 8,
  parameter int unsigned       MAX_HOLD     = 10,
  parameter logic [ADDR_W-1:0] BASE         = 16'h0100,
  parameter logic [ADDR_W-1:0] LIMIT        = 16'h01FF,
  parameter bit                INJECT_TOKEN = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rin_vld_i,
  input  logic              rin_tok_i,
  input  logic              rin_wr_i,
  input  logic [ADDR_W-1:0] rin_addr_i,
  input  logic [DATA_W-1:0] rin_data_i,
  output logic              rout_vld_o,
  output logic              rout_tok_o,
  output logic              rout_wr_o,
  output logic [ADDR_W-1:0] rout_addr_o,
  output logic [DATA_W-1:0] rout_data_o,
  input  logic              req_vld_i,
  output logic              req_rdy_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [CNT_W-1:0]  req_len_i,
  input  logic              req_wr_i,
  output logic              req_done_o,
  input  logic [DATA_W-1:0] snd_data_i,
  output logic              snd_pop_o,
  output logic              slv_vld_o,
  output logic              slv_wr_o,
  output logic [ADDR_W-1:0] slv_addr_o,
  output logic [DATA_W-1:0] slv_data_o
);
  logic              rin_hit, tok_in, slot_free;
  logic              emit_data, emit_tok, cur_wr, holding, job;
  logic [ADDR_W-1:0] cur_addr;

  assign tok_in    = rin_vld_i && rin_tok_i;
  assign slot_free = !rin_vld_i || rin_hit;

  tr_addr_match #(.ADDR_W(ADDR_W), .BASE(BASE), .LIMIT(LIMIT)) u_match (
    .vld_i  (rin_vld_i),
    .tok_i  (rin_tok_i),
    .addr_i (rin_addr_i),
    .hit_o  (rin_hit)
  );

  tr_tx_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAX_HOLD(MAX_HOLD)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tok_in_i    (tok_in),
    .slot_free_i (slot_free),
    .req_vld_i   (req_vld_i),
    .req_addr_i  (req_addr_i),
    .req_len_i   (req_len_i),
    .req_wr_i    (req_wr_i),
    .req_rdy_o   (req_rdy_o),
    .req_done_o  (req_done_o),
    .emit_data_o (emit_data),
    .emit_tok_o  (emit_tok),
    .cur_addr_o  (cur_addr),
    .cur_wr_o    (cur_wr),
    .holding_o   (holding),
    .job_o       (job),
    .snd_pop_o   (snd_pop_o)
  );

  tr_out_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INJECT_TOKEN(INJECT_TOKEN)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .emit_data_i (emit_data),
    .emit_tok_i  (emit_tok),
    .cur_addr_i  (cur_addr),
    .cur_wr_i    (cur_wr),
    .snd_data_i  (snd_data_i),
    .rin_vld_i   (rin_vld_i),
    .rin_tok_i   (rin_tok_i),
    .rin_wr_i    (rin_wr_i),
    .rin_addr_i  (rin_addr_i),
    .rin_data_i  (rin_data_i),
    .rin_hit_i   (rin_hit),
    .rout_vld_o  (rout_vld_o),
    .rout_tok_o  (rout_tok_o),
    .rout_wr_o   (rout_wr_o),
    .rout_addr_o (rout_addr_o),
    .rout_data_o (rout_data_o),
    .slv_vld_o   (slv_vld_o),
    .slv_wr_o    (slv_wr_o),
    .slv_addr_o  (slv_addr_o),
    .slv_data_o  (slv_data_o)
  );

  a_r2_token_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_in && !job && !holding) |=> (rout_vld_o && rout_tok_o));

  a_r3_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_in && job) |=> (rout_vld_o && !rout_tok_o && rout_addr_o == $past(cur_addr)));

  a_r5_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_done_o && holding && slot_free) |=> (rout_vld_o && rout_tok_o));

  a_r7_consume: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rin_hit |=> (slv_vld_o && slv_addr_o == $past(rin_addr_i)
                 && slv_data_o == $past(rin_data_i)));

  a_r8_forward: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rin_vld_i && !rin_tok_i && !rin_hit) |=>
      (rout_vld_o && !rout_tok_o && rout_addr_o == $past(rin_addr_i)
       && rout_data_o == $past(rin_data_i) && rout_wr_o == $past(rin_wr_i)));

  a_r11_read_no_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emit_data && !cur_wr) |-> !snd_pop_o);
endmodule

// File: tb/tr_node_tb.sv
module tr_node_tb;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned MAXH   = 3;
  localparam logic [DATA_W-1:0] DBASE = 32'hD000_0000;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk_i = ~clk_i;

  logic              rin_vld, rin_tok, rin_wr;
  logic [ADDR_W-1:0] rin_addr;
  logic [DATA_W-1:0] rin_data;
  logic              rout_vld, rout_tok, rout_wr;
  logic [ADDR_W-1:0] rout_addr;
  logic [DATA_W-1:0] rout_data;
  logic              req_vld, req_rdy, req_wr, req_done;
  logic [ADDR_W-1:0] req_addr;
  logic [CNT_W-1:0]  req_len;
  logic [DATA_W-1:0] snd_data;
  logic              snd_pop;
  logic              slv_vld, slv_wr;
  logic [ADDR_W-1:0] slv_addr;
  logic [DATA_W-1:0] slv_data;
  logic              ij_vld, ij_tok, ij_wr, ij_rdy, ij_done, ij_pop, ij_svld, ij_swr;
  logic [ADDR_W-1:0] ij_addr, ij_saddr;
  logic [DATA_W-1:0] ij_data, ij_sdata;

  int pops = 0;
  assign snd_data = DBASE + DATA_W'(pops);
  always @(posedge clk_i) if (rst_ni && snd_pop) pops <= pops + 1;

  tr_node #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .MAX_HOLD(MAXH),
            .BASE(16'h0100), .LIMIT(16'h01FF), .INJECT_TOKEN(1'b0)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rin_vld_i(rin_vld), .rin_tok_i(rin_tok), .rin_wr_i(rin_wr),
    .rin_addr_i(rin_addr), .rin_data_i(rin_data),
    .rout_vld_o(rout_vld), .rout_tok_o(rout_tok), .rout_wr_o(rout_wr),
    .rout_addr_o(rout_addr), .rout_data_o(rout_data),
    .req_vld_i(req_vld), .req_rdy_o(req_rdy), .req_addr_i(req_addr),
    .req_len_i(req_len), .req_wr_i(req_wr), .req_done_o(req_done),
    .snd_data_i(snd_data), .snd_pop_o(snd_pop),
    .slv_vld_o(slv_vld), .slv_wr_o(slv_wr), .slv_addr_o(slv_addr), .slv_data_o(slv_data)
  );

  tr_node #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .MAX_HOLD(MAXH),
            .BASE(16'h0100), .LIMIT(16'h01FF), .INJECT_TOKEN(1'b1)) u_dut_inj (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rin_vld_i(1'b0), .rin_tok_i(1'b0), .rin_wr_i(1'b0),
    .rin_addr_i('0), .rin_data_i('0),
    .rout_vld_o(ij_vld), .rout_tok_o(ij_tok), .rout_wr_o(ij_wr),
    .rout_addr_o(ij_addr), .rout_data_o(ij_data),
    .req_vld_i(1'b0), .req_rdy_o(ij_rdy), .req_addr_i('0),
    .req_len_i('0), .req_wr_i(1'b0), .req_done_o(ij_done),
    .snd_data_i('0), .snd_pop_o(ij_pop),
    .slv_vld_o(ij_svld), .slv_wr_o(ij_swr), .slv_addr_o(ij_saddr), .slv_data_o(ij_sdata)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: act=%0d exp=<20000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #2;
  endtask

  task automatic rin_idle();
    rin_vld = 0; rin_tok = 0; rin_wr = 0; rin_addr = '0; rin_data = '0;
  endtask

  task automatic rin_token();
    rin_vld = 1; rin_tok = 1; rin_wr = 0; rin_addr = '0; rin_data = '0;
  endtask

  task automatic issue(input logic [ADDR_W-1:0] a, input logic [CNT_W-1:0] n, input logic w);
    req_vld = 1; req_addr = a; req_len = n; req_wr = w;
    tick();
    req_vld = 0;
  endtask

  task automatic chk_word(input string req, input logic [ADDR_W-1:0] a,
                          input logic w, input logic [DATA_W-1:0] d);
    chk(rout_vld && !rout_tok, req, {rout_vld, rout_tok}, 2'b10);
    chk(rout_addr == a, req, rout_addr, a);
    chk(rout_wr == w, req, rout_wr, w);
    chk(rout_data == d, req, rout_data, d);
  endtask

  task automatic chk_token(input string req);
    chk(rout_vld && rout_tok, req, {rout_vld, rout_tok}, 2'b11);
  endtask

  // {tok, addr, data, expect_forward, expect_hit}
  localparam int VN = 8;
  localparam logic [50:0] VEC [VN] = '{
    {1'b0, 16'h0080, 32'hA000_0001, 1'b1, 1'b0},
    {1'b0, 16'h0100, 32'hA000_0002, 1'b0, 1'b1},
    {1'b0, 16'h01FF, 32'hA000_0003, 1'b0, 1'b1},
    {1'b0, 16'h00FF, 32'hA000_0004, 1'b1, 1'b0},
    {1'b0, 16'h0200, 32'hA000_0005, 1'b1, 1'b0},
    {1'b0, 16'h0150, 32'hA000_0006, 1'b0, 1'b1},
    {1'b0, 16'hFFFF, 32'hA000_0007, 1'b1, 1'b0},
    {1'b1, 16'h0000, 32'h0000_0000, 1'b1, 1'b0}
  };

  initial begin
    rin_idle();
    req_vld = 0; req_addr = '0; req_len = '0; req_wr = 0;
    #35;
    rst_ni = 1'b1;
    #2;
    // R1 reset state
    chk(!rout_vld, "R1 ring out empty", rout_vld, 0);
    chk(!slv_vld, "R1 slave idle", slv_vld, 0);
    chk(req_rdy, "R1 ready", req_rdy, 1);
    chk(ij_vld && ij_tok, "R1 injector token", {ij_vld, ij_tok}, 2'b11);
    tick();

    // R7/R8/R2 vector table
    for (int i = 0; i < VN; i++) begin
      logic vt, vf, vh;
      logic [ADDR_W-1:0] va;
      logic [DATA_W-1:0] vd;
      {vt, va, vd, vf, vh} = VEC[i];
      rin_vld = 1; rin_tok = vt; rin_wr = i[0]; rin_addr = va; rin_data = vd;
      tick();
      rin_idle();
      chk(rout_vld == vf, vh ? "R7 consumed" : "R8 forwarded", rout_vld, vf);
      if (vf) begin
        chk(rout_tok == vt, vt ? "R2 token forwarded" : "R8 flag", rout_tok, vt);
        if (!vt) begin
          chk(rout_addr == va && rout_data == vd && rout_wr == i[0],
              "R8 word unchanged", {rout_addr, rout_data}, {va, vd});
        end
      end
      chk(slv_vld == vh, "R7 slave strobe", slv_vld, vh);
      if (vh) begin
        chk(slv_addr == va && slv_data == vd && slv_wr == i[0],
            "R7 slave word", {slv_addr, slv_data}, {va, vd});
      end
    end
    tick();

    // R3/R4: five-word write, limit 3
    issue(16'h0300, 8'd5, 1'b1);
    chk(!req_rdy, "R3 busy after accept", req_rdy, 0);
    rin_token();
    tick();
    rin_idle();
    for (int k = 0; k < 3; k++) begin
      chk_word("R3 burst word", 16'h0300 + ADDR_W'(k), 1'b1, DBASE + DATA_W'(k));
      chk(!req_done, "R5 no early done", req_done, 0);
      tick();
    end
    chk_token("R4 release at limit");
    tick();
    chk(!rout_vld, "R4 slot empty after release", rout_vld, 0);
    // R6 second visit
    rin_token();
    tick();
    rin_idle();
    chk_word("R6 resumed word", 16'h0303, 1'b1, DBASE + 32'd3);
    tick();
    chk_word("R6 last word", 16'h0304, 1'b1, DBASE + 32'd4);
    chk(req_done, "R5 done with last word", req_done, 1);
    tick();
    chk_token("R5 token after last");
    chk(req_rdy, "R5 ready again", req_rdy, 1);
    tick();

    // R9/R11: read with foreign word mid-burst
    issue(16'h0400, 8'd2, 1'b0);
    rin_token();
    tick();
    rin_vld = 1; rin_tok = 0; rin_wr = 1; rin_addr = 16'h0800; rin_data = 32'hBEEF_0001;
    chk_word("R11 read word zero data", 16'h0400, 1'b0, 32'h0);
    tick();
    rin_idle();
    chk_word("R9 foreign word kept", 16'h0800, 1'b1, 32'hBEEF_0001);
    chk(!req_done, "R9 not done while stalled", req_done, 0);
    tick();
    chk_word("R9 own word resumes", 16'h0401, 1'b0, 32'h0);
    chk(req_done, "R9 done", req_done, 1);
    tick();
    chk_token("R9 token after read");
    chk(pops == 5, "R11 no pop on read", pops, 5);
    tick();

    // R10 zero length
    issue(16'h0500, 8'd0, 1'b1);
    chk(req_done, "R10 done for zero length", req_done, 1);
    rin_token();
    tick();
    rin_idle();
    chk_token("R10 token forwarded");
    tick();
    chk(!rout_vld, "R10 nothing sent", rout_vld, 0);
    chk(pops == 5, "R10 no pop", pops, 5);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule